// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns an 8-bit virtual address into an 8-bit physical address. It walks a two-level page table kept in a byte-addressed physical memory, then fetches the byte stored at the translated address. A request is a virtual address qualified by a valid strobe. The request is paired with a root-table base value that gives the physical location of the first-level table. The walker uses a single read port into memory. Read data comes back one cycle after the read is issued.

Pages are 16 bytes, so the low four address bits are the page offset and are never translated. The four remaining virtual bits are split evenly between the two levels. The upper pair indexes the first-level table and the lower pair indexes the second-level table. Each table entry is one byte, and its upper nibble names a physical page. That page holds either the second-level table or the data page. An entry whose page nibble is zero marks an unmapped region, and the walk stops there with a fault.

The walker handles one translation at a time. It reports busy from the cycle after it accepts a request until the cycle after its result. The result is a one-cycle pulse that carries the physical address, the fetched byte and a fault flag.

Top module: `ptw_walker`

## Requirements
- R1: During and directly after reset, `busy`, `mem_rd_en` and `rsp_valid` are all 0.
- R2: On a successful walk, `rsp_paddr[3:0]` equals bits [3:0] of the accepted virtual address.
- R3: The first memory read of a walk is at `root_base + vaddr[7:6]`, taken modulo 256, using the root value sampled together with the request.
- R4: The second read is at `{E1[7:4], 2'b00, vaddr[5:4]}`, where E1 is the byte returned by the first read.
- R5: The third read is at `{E2[7:4], vaddr[3:0]}`, where E2 is the byte returned by the second read. `rsp_paddr` equals that address, `rsp_data` equals the byte returned by that read, and `rsp_fault` is 0.
- R6: If E1[7:4] is zero, the walk ends with `rsp_fault`=1 after exactly one memory read.
- R7: If E1 is valid but E2[7:4] is zero, the walk ends with `rsp_fault`=1 after exactly two memory reads.
- R8: A faulting response drives `rsp_paddr` and `rsp_data` to zero.
- R9: `rsp_valid` is high for exactly one cycle. Counting from the rising edge that accepts the request, the response appears after the 6th edge for a full walk, the 4th edge for a second-level fault, and the 2nd edge for a first-level fault.
- R10: A request is accepted only while `busy` is 0. A request presented while busy produces no response and does not alter the walk in progress.
- R11: Entry bits [3:0] do not affect translation.
- R12: Each memory read strobe lasts one cycle, and a read is never issued in the cycle directly after another read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 8 | Virtual address to translate |
| root_base | input | 8 | Physical address of the first-level table |
| busy | output | 1 | A walk is in progress; requests are ignored |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 8 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 8 | Translated physical address (zero on fault) |
| rsp_data | output | 8 | Byte at the translated address (zero on fault) |
| rsp_fault | output | 1 | Walk hit an entry with a zero page field |

## Verification
The bench sweeps every pair of table indices under an aligned root. A walker that swapped or misplaced the index fields would then read the wrong entries and return wrong addresses. A root near the top of memory forces the first-level entry address to wrap. An adder that was too narrow or saturated would read outside the table. Table entries carry nonzero low bits, and a design that used those bits as part of the page number would shift its table and data addresses. Faults are placed at both levels to catch three errors: a further read after an invalid entry, wrong latency, and stale address or data left on a fault. Requests arriving mid-walk would start a second walk or corrupt the current one in a design that fails to ignore them.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Walk sequencing states; read states take two cycles (issue, capture).
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_L1   = 3'd1,
    ST_L2   = 3'd2,
    ST_DATA = 3'd3,
    ST_DONE = 3'd4
  } walk_state_e;

endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int PA_W  = 8,
  parameter int OFF_W = 4,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic [PA_W-1:0]  pte,
  output logic [PPN_W-1:0] ppn,
  output logic             present
);

  // Page number lives in the upper field of the entry byte.
  function automatic logic [PPN_W-1:0] entry_ppn(input logic [PA_W-1:0] e);
    return e[PA_W-1 -: PPN_W];
  endfunction

  // A zero page number marks an unmapped entry.
  function automatic logic entry_present(input logic [PPN_W-1:0] p);
    return |p;
  endfunction

  logic unused_low_bits;
  assign unused_low_bits = ^pte[OFF_W-1:0];

  assign ppn     = entry_ppn(pte);
  assign present = entry_present(ppn);

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int VA_W  = 8,
  parameter int PA_W  = 8,
  parameter int OFF_W = 4,
  parameter int L1_W  = 2,
  parameter int L2_W  = 2,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walk_state_e       state,
  input  logic [VA_W-1:0]   vaddr_q,
  input  logic [PA_W-1:0]   root_q,
  input  logic [PPN_W-1:0]  l1_ppn_q,
  input  logic [PPN_W-1:0]  l2_ppn_q,
  output logic [PA_W-1:0]   rd_addr
);

  // First-level entry: root plus the top index field, wrapping in PA_W bits.
  function automatic logic [PA_W-1:0] l1_entry_addr(input logic [PA_W-1:0] root,
                                                    input logic [VA_W-1:0] va);
    return root + PA_W'(va[VA_W-1 -: L1_W]);
  endfunction

  // Second-level entry: start of the table page plus the middle index field.
  function automatic logic [PA_W-1:0] l2_entry_addr(input logic [PPN_W-1:0] ppn,
                                                    input logic [VA_W-1:0] va);
    logic [PA_W-1:0] a;
    a = {ppn, {OFF_W{1'b0}}};
    a[L2_W-1:0] = va[OFF_W +: L2_W];
    return a;
  endfunction

  // Data byte: data page number joined with the untranslated offset.
  function automatic logic [PA_W-1:0] data_addr(input logic [PPN_W-1:0] ppn,
                                                input logic [VA_W-1:0] va);
    return {ppn, va[OFF_W-1:0]};
  endfunction

  always_comb begin
    case (state)
      ST_L1:   rd_addr = l1_entry_addr(root_q, vaddr_q);
      ST_L2:   rd_addr = l2_entry_addr(l1_ppn_q, vaddr_q);
      ST_DATA: rd_addr = data_addr(l2_ppn_q, vaddr_q);
      default: rd_addr = '0;
    endcase
  end

  AST_DATA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (rd_addr[OFF_W-1:0] == vaddr_q[OFF_W-1:0])); // R5

  AST_L2_TABLE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_L2) |-> (rd_addr[PA_W-1:OFF_W] == l1_ppn_q)); // R4

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
#(
  parameter int VA_W  = 8,
  parameter int PA_W  = 8,
  parameter int OFF_W = 4,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PA_W-1:0]   root_base,
  input  logic [PA_W-1:0]   mem_rd_data,
  input  logic              pte_present,
  input  logic [PPN_W-1:0]  pte_ppn,
  output walk_state_e       state,
  output logic [VA_W-1:0]   vaddr_q,
  output logic [PA_W-1:0]   root_q,
  output logic [PPN_W-1:0]  l1_ppn_q,
  output logic [PPN_W-1:0]  l2_ppn_q,
  output logic              busy,
  output logic              mem_rd_en,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [PA_W-1:0]   rsp_data,
  output logic              rsp_fault
);

  logic            phase;     // 0: read issued this cycle, 1: data returning
  logic            fault_q;
  logic [PA_W-1:0] data_q;

  // Named internal events for the checks below.
  logic evt_accept;
  logic evt_capture;
  logic in_read;

  assign in_read     = (state == ST_L1) || (state == ST_L2) || (state == ST_DATA);
  assign evt_accept  = (state == ST_IDLE) && req_valid;
  assign evt_capture = in_read && phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      vaddr_q  <= '0;
      root_q   <= '0;
      l1_ppn_q <= '0;
      l2_ppn_q <= '0;
      data_q   <= '0;
      fault_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            root_q  <= root_base;
            fault_q <= 1'b0;
            data_q  <= '0;
            phase   <= 1'b0;
            state   <= ST_L1;
          end
        end
        ST_L1: begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (pte_present) begin
              l1_ppn_q <= pte_ppn;
              state    <= ST_L2;
            end else begin
              fault_q <= 1'b1;
              state   <= ST_DONE;
            end
          end
        end
        ST_L2: begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (pte_present) begin
              l2_ppn_q <= pte_ppn;
              state    <= ST_DATA;
            end else begin
              fault_q <= 1'b1;
              state   <= ST_DONE;
            end
          end
        end
        ST_DATA: begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase  <= 1'b0;
            data_q <= mem_rd_data;
            state  <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign mem_rd_en = in_read && !phase;
  assign rsp_valid = (state == ST_DONE);
  assign rsp_fault = fault_q;
  assign rsp_paddr = fault_q ? '0 : {l2_ppn_q, vaddr_q[OFF_W-1:0]};
  assign rsp_data  = fault_q ? '0 : data_q;

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9

  AST_FAULT_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_data == '0)); // R8

  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !rsp_valid)); // R1

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0])); // R2

  AST_HOLD_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> ($stable(vaddr_q) && $stable(root_q))); // R10

  AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> mem_rd_en); // R3

  AST_CAPTURE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    evt_capture |-> $past(mem_rd_en)); // R12

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 8,
  parameter int PA_W  = 8,
  parameter int OFF_W = 4,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int L1_W  = VPN_W / 2,
  localparam int L2_W  = VPN_W - L1_W,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  root_base,
  output logic             busy,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic [PA_W-1:0]  mem_rd_data,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [PA_W-1:0]  rsp_data,
  output logic             rsp_fault
);

  walk_state_e      state;
  logic [VA_W-1:0]  vaddr_q;
  logic [PA_W-1:0]  root_q;
  logic [PPN_W-1:0] l1_ppn_q;
  logic [PPN_W-1:0] l2_ppn_q;
  logic [PPN_W-1:0] pte_ppn;
  logic             pte_present;

  ptw_pte_decode #(.PA_W(PA_W), .OFF_W(OFF_W)) u_decode (
    .pte     (mem_rd_data),
    .ppn     (pte_ppn),
    .present (pte_present)
  );

  ptw_fsm #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .root_base   (root_base),
    .mem_rd_data (mem_rd_data),
    .pte_present (pte_present),
    .pte_ppn     (pte_ppn),
    .state       (state),
    .vaddr_q     (vaddr_q),
    .root_q      (root_q),
    .l1_ppn_q    (l1_ppn_q),
    .l2_ppn_q    (l2_ppn_q),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .rsp_valid   (rsp_valid),
    .rsp_paddr   (rsp_paddr),
    .rsp_data    (rsp_data),
    .rsp_fault   (rsp_fault)
  );

  ptw_addr_gen #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W),
                 .L1_W(L1_W), .L2_W(L2_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .vaddr_q  (vaddr_q),
    .root_q   (root_q),
    .l1_ppn_q (l1_ppn_q),
    .l2_ppn_q (l2_ppn_q),
    .rd_addr  (mem_rd_addr)
  );

  AST_NO_RSP_WHILE_READING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !rsp_valid); // R9

endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_vaddr = '0;
  logic [7:0] root_base = '0;
  logic       busy;
  logic       mem_rd_en;
  logic [7:0] mem_rd_addr;
  logic [7:0] mem_rd_data = '0;
  logic       rsp_valid;
  logic [7:0] rsp_paddr;
  logic [7:0] rsp_data;
  logic       rsp_fault;

  always #5 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .root_base(root_base), .busy(busy), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_data(rsp_data),
    .rsp_fault(rsp_fault)
  );

  // Physical memory model, one-cycle read latency.
  logic [7:0] mem [0:255];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  typedef struct {
    logic [7:0] paddr;
    logic [7:0] data;
    logic       fault;
    int         lat;
    int         nreads;
    logic [7:0] a0, a1, a2;
    bit         lowbits;
    int         acc;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  bit   timeout = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference walk derived from the requirements.
  function automatic exp_t model(input logic [7:0] rb, input logic [7:0] va);
    exp_t e;
    logic [7:0] p1, p2;
    e = '{default: 0};
    e.a0 = rb + {6'd0, va[7:6]};
    p1 = mem[e.a0];
    e.lowbits = (p1[3:0] != 0);
    if (p1[7:4] == 0) begin
      e.fault = 1; e.nreads = 1; e.lat = 2; return e;
    end
    e.a1 = {p1[7:4], 2'b00, va[5:4]};
    p2 = mem[e.a1];
    e.lowbits = e.lowbits || (p2[3:0] != 0);
    if (p2[7:4] == 0) begin
      e.fault = 1; e.nreads = 2; e.lat = 4; return e;
    end
    e.a2 = {p2[7:4], va[3:0]};
    e.paddr = e.a2;
    e.data = mem[e.a2];
    e.nreads = 3; e.lat = 6;
    return e;
  endfunction

  // Driver: pushes expected item, presents one request.
  task automatic send(input logic [7:0] va, input logic [7:0] rb, input bit noisy);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e = model(rb, va);
    e.acc = cyc + 1;
    sb.push_back(e);
    req_valid = 1'b1; req_vaddr = va; root_base = rb;
    @(negedge clk);
    if (noisy) begin
      // R10: requests while busy must be ignored
      req_vaddr = va ^ 8'hF0; root_base = 8'hFE;
      repeat (3) @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // Monitor: collects reads, compares each response with the scoreboard.
  logic [7:0] rd_log [0:2];
  int  nrd = 0;
  bit  prev_rd = 0;
  bit  dbl_rd = 0;
  bit  prev_rsp = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_rsp) chk(!rsp_valid, "R9 pulse width", rsp_valid, 0);
        prev_rsp = rsp_valid;
        if (mem_rd_en) begin
          if (prev_rd) dbl_rd = 1;
          if (nrd < 3) rd_log[nrd] = mem_rd_addr;
          nrd++;
        end
        prev_rd = mem_rd_en;
        if (rsp_valid) begin
          if (sb.size() == 0) begin
            chk(0, "R10 unexpected response", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(rsp_fault == e.fault, e.nreads == 1 ? "R6 fault" :
                (e.nreads == 2 ? "R7 fault" : "R5 fault"), rsp_fault, e.fault);
            chk(cyc - e.acc == e.lat, "R9 latency", cyc - e.acc, e.lat);
            chk(nrd == e.nreads, "R12 read count", nrd, e.nreads);
            chk(!dbl_rd, "R12 back-to-back read", 1, 0);
            if (nrd >= 1) chk(rd_log[0] == e.a0, "R3 first read addr", rd_log[0], e.a0);
            if (nrd >= 2 && e.nreads >= 2)
              chk(rd_log[1] == e.a1, "R4 second read addr", rd_log[1], e.a1);
            if (nrd >= 3 && e.nreads >= 3)
              chk(rd_log[2] == e.a2, "R5 data read addr", rd_log[2], e.a2);
            if (e.fault) begin
              chk(rsp_paddr == 0 && rsp_data == 0, "R8 fault zeros",
                  {rsp_paddr, rsp_data}, 0);
            end else begin
              chk(rsp_paddr == e.paddr, e.lowbits ? "R11 paddr" : "R5 paddr",
                  rsp_paddr, e.paddr);
              chk(rsp_paddr[3:0] == e.paddr[3:0], "R2 offset", rsp_paddr[3:0], e.paddr[3:0]);
              chk(rsp_data == e.data, "R5 data", rsp_data, e.data);
            end
          end
          nrd = 0; dbl_rd = 0;
        end
      end
    end
  end

  task automatic run_all();
    // memory background and table entries (low nibbles nonzero for R11)
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 29 + 7) & 8'hFF);
    mem[8'h80] = 8'h91; mem[8'h81] = 8'hA3; mem[8'h82] = 8'h0E; mem[8'h83] = 8'hB5;
    mem[8'h90] = 8'h5F; mem[8'h91] = 8'h3B; mem[8'h92] = 8'h07; mem[8'h93] = 8'hC1;
    mem[8'hA0] = 8'h6D; mem[8'hA1] = 8'hE2; mem[8'hA2] = 8'h49; mem[8'hA3] = 8'h1A;
    mem[8'hB0] = 8'h29; mem[8'hB1] = 8'h00; mem[8'hB2] = 8'hF3; mem[8'hB3] = 8'h77;
    mem[8'hFE] = 8'hA0; mem[8'hFF] = 8'h90; mem[8'h00] = 8'hB2; mem[8'h01] = 8'h00;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !mem_rd_en && !rsp_valid, "R1 in reset",
          {busy, mem_rd_en, rsp_valid}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_rd_en && !rsp_valid, "R1 after reset",
        {busy, mem_rd_en, rsp_valid}, 0);

    // all index pairs under root 0x80, varied offsets
    for (int k = 0; k < 16; k++) send(8'((k << 4) | ((k * 5 + 3) & 15)), 8'h80, 1'b0);
    // wrapped first-level address (R3)
    for (int k = 0; k < 4; k++) send(8'((k << 6) | 8'h2C), 8'hFE, 1'b0);
    // R10: noise during a full walk, then a clean follow-up
    send(8'h1A, 8'h80, 1'b1);
    send(8'h77, 8'h80, 1'b1);
    send(8'hC6, 8'h80, 1'b0);
    repeat (12) @(negedge clk);
    chk(sb.size() == 0, "R10 outstanding responses", sb.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) chk(0, "watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule